// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read Timing

This block is an 18-bit-wide, 512-entry first-in first-out buffer. Its write side and read side each run on their own free-running clock. The two clocks may be unrelated, or they may be the same net. A word is stored on a rising write-clock edge while the write enable is high. It is removed on a rising read-clock edge while the read enable is high. Each side's pointer reaches the other side as Gray code through a two-flop synchroniser. Each side therefore sees the other side's progress a little late, and only ever in the safe direction.

A static mode input chooses the read timing:
- **Standard mode.** A word reaches the output register only when a read is requested.
- **Fall-through mode.** The oldest word is moved into the output register on its own, and a read enable consumes the word that is already shown.

The data-present flag follows the same mode:
- In standard mode it reports an empty memory.
- In fall-through mode it reports that the output register holds no word.

Besides the empty and full status, the block reports almost-empty, almost-full and half-full levels. The two thresholds are offsets held in registers. While the load strobe is high, each write-enable cycle diverts the low bits of the write bus into these registers in turn, and no word is stored. An output gate forces the read bus to zero while it is low.

Top module: `xclk_fifo`

## Requirements
- R1: After reset the block shows these flags:

  | Flag | Value after reset |
  |---|---|
  | `no_data` | 1 |
  | `no_room` | 0 |
  | `almost_empty` | 1 |
  | `almost_full` | 0 |
  | `half_full` | 0 |

  Both threshold offsets are reset to 7.
- R2: Words leave in the order they were written, and all 512 entries can be filled. In standard mode, a write at read-clock edge k clears `no_data` after edge k+2. Each read enable on a non-empty buffer places the next word on `rd_data` at that edge.
- R3: When 512 words are stored, `no_room` is 1. A write in that state is ignored: the extra word never leaves the buffer.
- R4: In standard mode, a read enable while `no_data` is 1 changes neither `rd_data` nor the stored contents.
- R5: In fall-through mode (`fwft_mode`=1), a word written into an empty buffer at edge k appears on `rd_data` after edge k+3 without any read enable. `no_data` falls at the same edge.
- R6: In fall-through mode, the shown word is held until a read enable consumes it. That edge shows the next word, or raises `no_data` if no word is left. A read enable while `no_data` is 1 is ignored.
- R7: `almost_empty` is 1 when the read-side memory level is at or below the almost-empty offset.
- R8: `almost_full` is 1 when the write-side level is at or above 512 minus the almost-full offset.
- R9: `half_full` is 1 when the write-side level is above 256.
- R10: While `ofs_load` is 1, each write-enable cycle writes `wr_data[9:0]` into the almost-empty offset, then the almost-full offset, and after that wraps back to the almost-empty offset. The order restarts at the almost-empty offset whenever `ofs_load` is 0. Load cycles store no word.
- R11: While `out_en` is 0, `rd_data` is zero. The output register and the stored contents are kept, and reappear when `out_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_data | input | 18 | Write data; bits 9:0 also carry offsets during a load |
| ofs_load | input | 1 | Offset load strobe |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read enable |
| fwft_mode | input | 1 | 1 selects fall-through read timing, 0 selects standard timing |
| out_en | input | 1 | Output gate for `rd_data` |
| rd_data | output | 18 | Read data |
| no_data | output | 1 | Empty (standard mode) or output not ready (fall-through mode) |
| no_room | output | 1 | Full, or not ready for input |
| almost_empty | output | 1 | Read-side level at or below the almost-empty offset |
| almost_full | output | 1 | Write-side level within the almost-full offset of full |
| half_full | output | 1 | Write-side level above half the depth |

## Verification
The bench targets the following corner cases:
- **Flag latency.** It checks the exact edge at which `no_data` falls in both modes. An extra or a missing synchroniser stage would shift that edge by one.
- **Completely full buffer.** It fills all 512 entries and then writes once more. A design that wrapped its pointer would later return the intruding word, or would lose the whole contents.
- **Threshold limits.** The threshold flags are tested one word on either side of their limits. An off-by-one compare would show up there.
- **Offset load order.** A three-value load checks the wrap-around. A second one-value load checks that the order restarts, which a sequencer that failed to reset its select would get wrong.
- **Fall-through reads with no word present.** In fall-through mode the bench issues reads while no word is present. This catches a design that consumes a phantom word or drops the next real one.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    // Which threshold register the next load cycle writes.
    typedef enum logic {
        OFS_EMPTY_SIDE = 1'b0,
        OFS_FULL_SIDE  = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/xf_gray_sync.sv
module xf_gray_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/xf_ram.sv
module xf_ram #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem [N];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xf_wr_ctrl.sv
module xf_wr_ctrl
    import xclk_fifo_pkg::*;
#(
    parameter int AW     = 9,
    parameter int DEF_AE = 7,
    parameter int DEF_AF = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        load,
    input  logic [AW:0] din,
    input  logic [AW:0] rgray_sync,
    output logic        mem_we,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray,
    output logic [AW:0] ae_ofs,
    output logic [AW:0] af_ofs,
    output logic        full,
    output logic        afull,
    output logic        hfull
);
    localparam logic [AW:0]   DEPTH_V = (AW+1)'(1) << AW;
    localparam logic [AW:0]   HALF_V  = DEPTH_V >> 1;
    localparam logic [AW+1:0] DEPTH_W = {1'b0, DEPTH_V};

    typedef struct packed {
        logic [AW:0] wbin;
        logic [AW:0] wgray;
        logic [AW:0] ae;
        logic [AW:0] af;
        ofs_sel_e    sel;
    } wst_t;

    wst_t st_d, st_q;
    logic [AW:0] rbin;
    logic [AW:0] level;
    logic        push;
    logic [AW:0] wnext;

    always_comb begin
        for (int i = 0; i <= AW; i++) rbin[i] = ^(rgray_sync >> i);
        level = st_q.wbin - rbin;
        full  = (level == DEPTH_V);
        afull = ({1'b0, level} + {1'b0, st_q.af}) >= DEPTH_W;
        hfull = level > HALF_V;
        push  = wr_en && !load && !full;
        wnext = st_q.wbin + 1'b1;

        st_d = st_q;
        if (push) begin
            st_d.wbin  = wnext;
            st_d.wgray = wnext ^ (wnext >> 1);
        end
        if (load) begin
            if (wr_en) begin
                if (st_q.sel == OFS_EMPTY_SIDE) begin
                    st_d.ae  = din;
                    st_d.sel = OFS_FULL_SIDE;
                end else begin
                    st_d.af  = din;
                    st_d.sel = OFS_EMPTY_SIDE;
                end
            end
        end else begin
            st_d.sel = OFS_EMPTY_SIDE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wbin  <= '0;
            st_q.wgray <= '0;
            st_q.ae    <= (AW+1)'(DEF_AE);
            st_q.af    <= (AW+1)'(DEF_AF);
            st_q.sel   <= OFS_EMPTY_SIDE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we = push;
    assign waddr  = st_q.wbin[AW-1:0];
    assign wgray  = st_q.wgray;
    assign ae_ofs = st_q.ae;
    assign af_ofs = st_q.af;

    assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !load && full) |=> $stable(st_q.wbin));
    assert_level_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_V);
    assert_load_stores_nothing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $stable(st_q.wbin));
    assert_gray_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.wgray ^ $past(st_q.wgray)) <= 1);
endmodule

// File: rtl/xf_rd_ctrl.sv
module xf_rd_ctrl #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          fwft,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW:0]   ae_ofs,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          no_data,
    output logic          aempty
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(1) << AW;

    typedef struct packed {
        logic [AW:0]   rbin;
        logic [AW:0]   rgray;
        logic [DW-1:0] dout;
        logic          ovld;
    } rst_t;

    rst_t st_d, st_q;
    logic [AW:0] wbin;
    logic [AW:0] level;
    logic        empty;
    logic        pop;
    logic [AW:0] rnext;

    always_comb begin
        for (int i = 0; i <= AW; i++) wbin[i] = ^(wgray_sync >> i);
        level = wbin - st_q.rbin;
        empty = (level == '0);
        rnext = st_q.rbin + 1'b1;
        pop   = 1'b0;

        st_d = st_q;
        if (fwft) begin
            if (!empty && (!st_q.ovld || rd_en)) begin
                pop       = 1'b1;
                st_d.dout = rdata;
                st_d.ovld = 1'b1;
            end else if (rd_en) begin
                st_d.ovld = 1'b0;
            end
        end else begin
            st_d.ovld = 1'b0;
            if (rd_en && !empty) begin
                pop       = 1'b1;
                st_d.dout = rdata;
            end
        end
        if (pop) begin
            st_d.rbin  = rnext;
            st_d.rgray = rnext ^ (rnext >> 1);
        end

        no_data = fwft ? !st_q.ovld : empty;
        aempty  = level <= ae_ofs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr = st_q.rbin[AW-1:0];
    assign rgray = st_q.rgray;
    assign dout  = st_q.dout;

    assert_std_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && rd_en && empty) |=> ($stable(st_q.dout) && $stable(st_q.rbin)));
    assert_fwft_holds_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && st_q.ovld && !rd_en) |=> $stable(st_q.dout));
    assert_fwft_phantom_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && !st_q.ovld && empty) |=> $stable(st_q.rbin));
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_V);
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int DW     = 18,
    parameter int DEPTH  = 512,
    parameter int DEF_AE = 7,
    parameter int DEF_AF = 7
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ofs_load,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic          fwft_mode,
    input  logic          out_en,
    output logic [DW-1:0] rd_data,
    output logic          no_data,
    output logic          no_room,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          half_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_rdata, dout;
    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
    logic [PW-1:0] ae_ofs, af_ofs;

    xf_wr_ctrl #(.AW(AW), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .load(ofs_load),
        .din(wr_data[PW-1:0]), .rgray_sync(rgray_ws), .mem_we(mem_we),
        .waddr(waddr), .wgray(wgray), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .full(no_room), .afull(almost_full), .hfull(half_full)
    );

    xf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    xf_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rs)
    );

    xf_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_ws)
    );

    xf_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .fwft(fwft_mode),
        .wgray_sync(wgray_rs), .ae_ofs(ae_ofs), .rdata(mem_rdata),
        .raddr(raddr), .rgray(rgray), .dout(dout), .no_data(no_data),
        .aempty(almost_empty)
    );

    assign rd_data = out_en ? dout : '0;
endmodule

// File: tb/test_xclk_fifo.sv
module test_xclk_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, ofs_load = 1'b0, rd_en = 1'b0;
    logic        fwft_mode = 1'b0, out_en = 1'b1;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        no_data, no_room, almost_empty, almost_full, half_full;

    int errors = 0;
    int checks = 0;
    logic [17:0] sb[$];
    logic [17:0] held;

    always #5 clk = ~clk;

    xclk_fifo i_xclk_fifo (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ofs_load(ofs_load), .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en),
        .fwft_mode(fwft_mode), .out_en(out_en), .rd_data(rd_data),
        .no_data(no_data), .no_room(no_room), .almost_empty(almost_empty),
        .almost_full(almost_full), .half_full(half_full)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one write cycle; the expected word goes to the scoreboard if it should be stored.
    task automatic wr(input logic [17:0] d, input bit keep);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (keep) sb.push_back(d);
    endtask

    task automatic rd(input int n);
        rd_en = 1'b1;
        repeat (n) @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: compares each consumed word against the scoreboard.
    always @(posedge clk) begin
        if (rst_n && rd_en && !no_data) begin
            if (fwft_mode) begin
                if (sb.size() == 0) check("R6 unexpected word", {14'h0, rd_data}, 32'hFFFF_FFFF);
                else check("R6 fall-through order", {14'h0, rd_data}, {14'h0, sb.pop_front()});
            end else begin
                @(negedge clk);
                if (sb.size() == 0) check("R2 unexpected word", {14'h0, rd_data}, 32'hFFFF_FFFF);
                else check("R2 read order", {14'h0, rd_data}, {14'h0, sb.pop_front()});
            end
        end
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 no_data", no_data, 1);
        check("R1 no_room", no_room, 0);
        check("R1 almost_empty", almost_empty, 1);
        check("R1 almost_full", almost_full, 0);
        check("R1 half_full", half_full, 0);

        // R2 standard-mode latency and order
        wr(18'h00011, 1);
        check("R2 no_data after k", no_data, 1);
        idle(1);
        check("R2 no_data after k+1", no_data, 1);
        idle(1);
        check("R2 no_data after k+2", no_data, 0);
        for (int i = 0; i < 4; i++) wr(18'h00100 + 18'(i), 1);
        idle(3);
        rd(5);
        idle(1);
        held = rd_data;
        // R4 read while empty
        check("R4 empty flag", no_data, 1);
        rd(1);
        idle(1);
        check("R4 data held", {14'h0, rd_data}, {14'h0, held});

        // R7 default almost-empty offset 7
        for (int i = 0; i < 7; i++) wr(18'h01000 + 18'(i), 1);
        idle(3);
        check("R7 level 7", almost_empty, 1);
        wr(18'h01007, 1);
        idle(3);
        check("R7 level 8", almost_empty, 0);
        rd(8);
        idle(3);

        // R9, R8, R3 fill to the top
        for (int i = 0; i < 512; i++) begin
            wr(18'h20000 + 18'(i), 1);
            if (i == 255) check("R9 level 256", half_full, 0);
            if (i == 256) check("R9 level 257", half_full, 1);
            if (i == 503) check("R8 level 504", almost_full, 0);
            if (i == 504) check("R8 level 505", almost_full, 1);
            if (i == 510) check("R3 not full at 511", no_room, 0);
        end
        check("R3 full at 512", no_room, 1);
        wr(18'h3DEAD, 0);
        check("R3 still full", no_room, 1);
        idle(2);
        rd(512);
        idle(3);
        check("R3 drained", no_data, 1);
        check("R3 scoreboard empty", sb.size(), 0);

        // R10 offset load: 20 -> AE, 500 -> AF, 3 wraps to AE
        ofs_load = 1'b1;
        wr(18'd20, 0);
        wr(18'd500, 0);
        wr(18'd3, 0);
        ofs_load = 1'b0;
        idle(3);
        check("R10 load stores no word", no_data, 1);
        check("R8 af at level 0", almost_full, 0);
        for (int i = 0; i < 3; i++) wr(18'h04000 + 18'(i), 1);
        idle(3);
        check("R10 wrapped AE=3 level 3", almost_empty, 1);
        wr(18'h04003, 1);
        idle(3);
        check("R10 wrapped AE=3 level 4", almost_empty, 0);
        for (int i = 4; i < 11; i++) wr(18'h04000 + 18'(i), 1);
        check("R10 AF=500 level 11", almost_full, 0);
        wr(18'h0400B, 1);
        check("R10 AF=500 level 12", almost_full, 1);
        rd(12);
        idle(3);
        // R10 restart at AE
        ofs_load = 1'b1;
        wr(18'd7, 0);
        ofs_load = 1'b0;
        for (int i = 0; i < 5; i++) wr(18'h05000 + 18'(i), 1);
        idle(3);
        check("R10 restart AE=7 level 5", almost_empty, 1);
        rd(5);
        idle(3);

        // R11 output gate
        wr(18'h2AAAA, 1);
        idle(3);
        rd(1);
        idle(1);
        out_en = 1'b0;
        idle(1);
        check("R11 gated", {14'h0, rd_data}, 0);
        out_en = 1'b1;
        idle(1);
        check("R11 restored", {14'h0, rd_data}, 32'h2AAAA);

        // R5 fall-through latency
        fwft_mode = 1'b1;
        idle(2);
        wr(18'h1A5A5, 1);
        check("R5 after k", no_data, 1);
        idle(1);
        check("R5 after k+1", no_data, 1);
        idle(1);
        check("R5 after k+2", no_data, 1);
        idle(1);
        check("R5 after k+3 flag", no_data, 0);
        check("R5 after k+3 data", {14'h0, rd_data}, 32'h1A5A5);
        // R6 hold and consume
        wr(18'h0BBBB, 1);
        wr(18'h0CCCC, 1);
        idle(3);
        check("R6 held", {14'h0, rd_data}, 32'h1A5A5);
        rd(3);
        check("R6 exhausted", no_data, 1);
        rd(1);
        check("R6 phantom read", no_data, 1);
        check("R6 data kept", {14'h0, rd_data}, 32'h0CCCC);
        wr(18'h0DDDD, 1);
        idle(4);
        check("R6 next word", {14'h0, rd_data}, 32'h0DDDD);
        check("R6 scoreboard", sb.size(), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule